// File: doc/BRIEF.md
# Five-Port Mesh Router with XY Wormhole Switching

This block is the switching element placed at one node of a 4x4 two-dimensional mesh. It has five ports: one to the attached core (local) and one to each of the north, south, east and west neighbours. Every port moves 34-bit flits with a valid/ready handshake in each direction. Every input has a small FIFO. A packet is steered by dimension-ordered routing: it first moves horizontally until its column matches the destination, then vertically, and it then leaves on the local port.

Each output port is held by one packet at a time. The header flit claims the output, and the claim stays until the tail flit has left. Body flits follow the same path without looking at their payload. When several waiting headers want the same free output, a rotating-priority arbiter picks one. The node's place in the mesh comes from the `NODE_ID` parameter. IDs count row by row from the upper-left corner, so column = ID mod 4 and row = ID div 4. Rows grow southward.

Top module: `mesh_xy_router`

## Requirements
- R1: While reset is asserted and right after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Port indices are 0 local, 1 north, 2 south, 3 east, 4 west. The destination node ID sits in flit bits [3:0] of a header. With dest column > own column the flit leaves east, with a smaller column west. With equal columns, a larger dest row goes south, a smaller one north, and an equal one goes local.
- R3: Flit bits [33:32] give the type: 01 header, 00 body, 10 tail. Once a header is granted an output, that output carries only flits from the same input until the tail has been transferred. Other headers for that output wait.
- R4: Type 11 is a single-flit packet. It claims the output and releases it in the same transfer.
- R5: When several inputs hold headers for the same free output, the grant rotates. The input that won last gets the lowest priority next. After reset, input 0 ranks first.
- R6: Each input buffers up to 4 flits and drops `in_ready` while full. A flit offered while `in_ready` is low is not taken and never appears at an output.
- R7: Flits of one packet leave in the order they were accepted.
- R8: While an output shows a valid flit and its `out_ready` is low, the flit and its valid stay unchanged.
- R9: A flit accepted on a clock edge into an empty FIFO, bound for a free output, shows on that output in the following cycle.
- R10: The router never raises valid on a port that faces off the mesh edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_flit | input | 5x34 | Incoming flit per port |
| in_valid | input | 5 | Incoming flit present, per port |
| in_ready | output | 5 | Input FIFO can take a flit, per port |
| out_flit | output | 5x34 | Outgoing flit per port |
| out_valid | output | 5 | Outgoing flit present, per port |
| out_ready | input | 5 | Downstream accepts the flit, per port |

## Verification
The assertions assume well-formed traffic. Every packet opens with a header or is a single flit, and it closes with a tail. Header destinations are valid node IDs that never point back toward the port the packet came from. The bench only builds packets of that form. It uses node 4, whose west port lies on the mesh edge, and it sends nothing there. That leaves the edge assertion something real to watch.

// File: rtl/mesh_xy_router.sv
module mesh_xy_router #(
  parameter int MESH_W     = 4,
  parameter int MESH_H     = 4,
  parameter int NODE_ID    = 5,
  parameter int FLIT_W     = 34,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0][FLIT_W-1:0] in_flit,
  input  logic [4:0]             in_valid,
  output logic [4:0]             in_ready,
  output logic [4:0][FLIT_W-1:0] out_flit,
  output logic [4:0]             out_valid,
  input  logic [4:0]             out_ready
);
  localparam int NP    = 5;
  localparam int ID_W  = $clog2(MESH_W*MESH_H);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);
  localparam int MY_X  = NODE_ID % MESH_W;
  localparam int MY_Y  = NODE_ID / MESH_W;

  function automatic logic [2:0] route(input logic [ID_W-1:0] d);
    int dx, dy;
    dx = int'(d) % MESH_W;
    dy = int'(d) / MESH_W;
    if (dx > MY_X)      return 3'd3;
    else if (dx < MY_X) return 3'd4;
    else if (dy > MY_Y) return 3'd2;
    else if (dy < MY_Y) return 3'd1;
    else                return 3'd0;
  endfunction

  logic [FLIT_W-1:0]         mem [NP][FIFO_DEPTH];
  logic [NP-1:0][PTR_W-1:0]  rd_q, wr_q;
  logic [NP-1:0][CNT_W-1:0]  cnt_q;
  logic [NP-1:0]             busy_q;
  logic [NP-1:0][2:0]        owner_q, rr_q;

  logic [NP-1:0][FLIT_W-1:0] head;
  logic [NP-1:0][2:0]        want, grant_in, sel;
  logic [NP-1:0]             nonempty, holds, grant_v, pop;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      head[i]     = mem[i][rd_q[i]];
      nonempty[i] = cnt_q[i] != '0;
      want[i]     = route(head[i][ID_W-1:0]);
      in_ready[i] = cnt_q[i] != CNT_W'(FIFO_DEPTH);
      holds[i]    = 1'b0;
      for (int o = 0; o < NP; o++)
        if (busy_q[o] && owner_q[o] == 3'(i)) holds[i] = 1'b1;
    end
    pop = '0;
    for (int o = 0; o < NP; o++) begin
      grant_v[o]  = 1'b0;
      grant_in[o] = 3'd0;
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = (int'(rr_q[o]) + k) % NP;
        if (!grant_v[o] && !busy_q[o] && nonempty[idx] && !holds[idx] &&
            head[idx][FLIT_W-2] && want[idx] == 3'(o)) begin
          grant_v[o]  = 1'b1;
          grant_in[o] = 3'(idx);
        end
      end
      sel[o]       = busy_q[o] ? owner_q[o] : grant_in[o];
      out_valid[o] = busy_q[o] ? nonempty[owner_q[o]] : grant_v[o];
      out_flit[o]  = head[sel[o]];
      if (out_valid[o] && out_ready[o]) pop[sel[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (in_valid[i] && in_ready[i]) mem[i][wr_q[i]] <= in_flit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= '0;
      owner_q <= '0;
      rr_q    <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (in_valid[i] && in_ready[i])
          wr_q[i] <= (wr_q[i] == PTR_W'(FIFO_DEPTH-1)) ? '0 : wr_q[i] + 1'b1;
        if (pop[i])
          rd_q[i] <= (rd_q[i] == PTR_W'(FIFO_DEPTH-1)) ? '0 : rd_q[i] + 1'b1;
        cnt_q[i] <= cnt_q[i] + CNT_W'(in_valid[i] && in_ready[i]) - CNT_W'(pop[i]);
      end
      for (int o = 0; o < NP; o++) begin
        if (grant_v[o]) begin
          busy_q[o]  <= 1'b1;
          owner_q[o] <= grant_in[o];
          rr_q[o]    <= (grant_in[o] == 3'(NP-1)) ? 3'd0 : grant_in[o] + 3'd1;
        end
        if (out_valid[o] && out_ready[o] && out_flit[o][FLIT_W-1]) busy_q[o] <= 1'b0;
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out_chk
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o]));
    // R2
    xy_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && out_flit[o][FLIT_W-2] |-> route(out_flit[o][ID_W-1:0]) == 3'(o));
    // R3
    body_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_flit[o][FLIT_W-2] |-> busy_q[o]);
  end

  for (genvar i = 0; i < NP; i++) begin : g_in_chk
    logic [NP-1:0] from_i;
    always_comb
      for (int o = 0; o < NP; o++) from_i[o] = out_valid[o] && sel[o] == 3'(i);
    // R3
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(from_i));
  end

  if (MY_X == 0) begin : g_w_edge
    // R10
    west_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) !out_valid[4]);
  end
  if (MY_X == MESH_W-1) begin : g_e_edge
    // R10
    east_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) !out_valid[3]);
  end
  if (MY_Y == 0) begin : g_n_edge
    // R10
    north_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) !out_valid[1]);
  end
  if (MY_Y == MESH_H-1) begin : g_s_edge
    // R10
    south_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) !out_valid[2]);
  end
endmodule

// File: tb/mesh_xy_router_tb_top.sv
module mesh_xy_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0][FW-1:0] in_flit = '0;
  logic [4:0] in_valid = '0;
  logic [4:0] in_ready;
  logic [4:0][FW-1:0] out_flit;
  logic [4:0] out_valid;
  logic [4:0] out_ready = '1;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesh_xy_router #(.NODE_ID(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_valid(in_valid),
    .in_ready(in_ready), .out_flit(out_flit), .out_valid(out_valid), .out_ready(out_ready)
  );

  // {input port[2:0], dest[3:0], expected output[2:0]} for node 4 (column 0, row 1)
  localparam logic [9:0] VEC [0:9] = '{
    {3'd0, 4'd7,  3'd3}, {3'd0, 4'd0,  3'd1}, {3'd0, 4'd12, 3'd2}, {3'd0, 4'd1, 3'd3},
    {3'd0, 4'd15, 3'd3}, {3'd2, 4'd4,  3'd0}, {3'd3, 4'd8,  3'd2}, {3'd1, 4'd4, 3'd0},
    {3'd3, 4'd0,  3'd1}, {3'd1, 4'd13, 3'd3}
  };

  function automatic logic [FW-1:0] mk(input logic [1:0] t, input logic [27:0] pl, input logic [3:0] d);
    return {t, pl, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    out_ready = '1;
    @(negedge clk);
    chk("R1", 64'(out_valid), 64'h0);
    chk("R1", 64'(in_ready), 64'h1f);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(out_valid), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f, h0, b0, t0, h2, t2, s0, s2, s0b;
    do_reset();

    // R2 R9 R10: routing table, one single-flit packet at a time
    for (int v = 0; v < 10; v++) begin
      logic [2:0] ip, ep;
      ip = VEC[v][9:7];
      ep = VEC[v][2:0];
      f = mk(2'b11, 28'(v*17+3), VEC[v][6:3]);
      in_flit[ip] = f;
      in_valid[ip] = 1'b1;
      @(negedge clk);
      chk("R2", 64'(out_valid), 64'(5'b1 << ep));
      chk("R9", 64'(out_flit[ep]), 64'(f));
      in_valid = '0;
      @(negedge clk);
    end

    // R5 R4: rotation between input 0 and input 2 for the east port
    do_reset();
    s0 = mk(2'b11, 28'h111, 4'd7);
    s2 = mk(2'b11, 28'h222, 4'd7);
    s0b = mk(2'b11, 28'h333, 4'd7);
    in_flit[0] = s0; in_flit[2] = s2; in_valid = 5'b00101;
    @(negedge clk);
    chk("R5", 64'(out_flit[3]), 64'(s0));
    in_valid = 5'b00001; in_flit[0] = s0b;
    @(negedge clk);
    in_valid = '0;
    chk("R5", 64'(out_flit[3]), 64'(s2));
    @(negedge clk);
    chk("R4", 64'(out_flit[3]), 64'(s0b));
    chk("R4", 64'(out_valid[3]), 64'd1);
    @(negedge clk);

    // R3 R7: wormhole lock holds out a competing header
    do_reset();
    h0 = mk(2'b01, 28'hA0, 4'd7); b0 = mk(2'b00, 28'hA1, 4'd7); t0 = mk(2'b10, 28'hA2, 4'd7);
    h2 = mk(2'b01, 28'hB0, 4'd7); t2 = mk(2'b10, 28'hB1, 4'd7);
    in_flit[0] = h0; in_flit[2] = h2; in_valid = 5'b00101;
    @(negedge clk);
    chk("R3", 64'(out_flit[3]), 64'(h0));
    in_valid = 5'b00001; in_flit[0] = b0;
    @(negedge clk);
    chk("R3", 64'(out_flit[3]), 64'(b0));
    in_flit[0] = t0;
    @(negedge clk);
    chk("R7", 64'(out_flit[3]), 64'(t0));
    in_valid = '0;
    @(negedge clk);
    chk("R3", 64'(out_flit[3]), 64'(h2));
    in_flit[2] = t2; in_valid = 5'b00100;
    @(negedge clk);
    chk("R3", 64'(out_flit[3]), 64'(t2));
    in_valid = '0;
    @(negedge clk);
    chk("R3", 64'(out_valid), 64'h0);

    // R6 R8 R7: fill FIFO against a stalled output
    do_reset();
    out_ready[3] = 1'b0;
    for (int n = 0; n < 4; n++) begin
      in_flit[0] = mk(n == 0 ? 2'b01 : 2'b00, 28'(n + 'h50), 4'd7);
      in_valid[0] = 1'b1;
      @(negedge clk);
    end
    chk("R6", 64'(in_ready[0]), 64'd0);
    chk("R8", 64'(out_flit[3]), 64'(mk(2'b01, 28'h50, 4'd7)));
    in_flit[0] = mk(2'b00, 28'hBAD, 4'd7);
    @(negedge clk);
    in_valid = '0;
    chk("R8", 64'(out_flit[3]), 64'(mk(2'b01, 28'h50, 4'd7)));
    out_ready[3] = 1'b1;
    @(negedge clk);
    chk("R6", 64'(in_ready[0]), 64'd1);
    for (int n = 1; n < 4; n++) begin
      chk("R7", 64'(out_flit[3]), 64'(mk(2'b00, 28'(n + 'h50), 4'd7)));
      @(negedge clk);
    end
    chk("R6", 64'(out_valid[3]), 64'd0);
    in_flit[0] = mk(2'b10, 28'h5F, 4'd7);
    in_valid[0] = 1'b1;
    @(negedge clk);
    in_valid = '0;
    chk("R7", 64'(out_flit[3]), 64'(mk(2'b10, 28'h5F, 4'd7)));
    @(negedge clk);
    chk("R3", 64'(out_valid), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule